// File: doc/BRIEF.md
# Multi-Drive Interrupt Request Queue

This block collects interrupt causes for a disk controller that serves eight drives and presents them to the bus as one request line. The controller has one cause of its own: a command or transfer has finished and DONE is set. Each drive has a second cause: a seek it was given has reached its cylinder. Each cause sits in its own bit of a nine-bit pending queue. When the bus acknowledges, the block serves the pending cause with the highest priority, removes it from the queue, and places the number of the drive that caused it in a three-bit drive-identity field. If more causes are still waiting, the block raises the request line again.

The controller's command logic drives a set of single-cycle strobes into the block: DONE set, DONE cleared, seek completed (with a drive number), a write of the control register (with its interrupt-enable bit), a command start (with the drive it addresses), and the bus acknowledge. The block keeps its own copies of DONE and of the interrupt enable. A control state machine decides whether the request line is up. It has three states. ST_IDLE means nothing is pending. ST_HOLD means causes are pending but the line is down. ST_RAISED means the line is up. The transitions are named as follows. "raise" moves to ST_RAISED when a set event asserts the request. "park" moves to ST_HOLD when the line is dropped and causes remain. "drain" returns to ST_IDLE when the queue empties. Each state stays where it is when none of these fire.

Top module: `irqq_top`

## Requirements
- R1: Queue bit 0 holds the controller-done cause. Bit n+1 holds the seek-complete cause of drive n, for n = 0 to 7. The queue is visible on `intq_o`.
- R2: An acknowledge serves the lowest-numbered set bit and clears it. After that, `irq_o` is high if and only if some bit is still set.
- R3: When an acknowledge serves bit 0, `drive_id_o` takes the drive number captured by the most recent `cmd_load_i` strobe. When it serves bit k > 0, `drive_id_o` takes k-1.
- R4: An acknowledge that finds the queue empty leaves the queue clear, drops `irq_o` and sets `vector_o` to 0. An acknowledge that finds the queue non-empty sets `vector_o` to the parameter VECTOR (default 8'h90). `vector_o` holds its value between acknowledges.
- R5: A DONE-set event with interrupts enabled queues bit 0 and raises `irq_o`. With interrupts disabled, the same event clears the whole queue and drops `irq_o`.
- R6: A DONE-clear event clears only bit 0 and drops `irq_o`. The drive bits keep their values.
- R7: A seek-complete event for drive n with interrupts enabled sets bit n+1. It raises `irq_o` only if DONE is 1. With interrupts disabled, the event clears the queue and drops `irq_o`.
- R8: A control write with the enable bit at 0 clears the queue and drops `irq_o`. A control write with the enable bit at 1, while DONE is 1 and the enable was 0 before the write, queues bit 0 and raises `irq_o`. A write of enable 1 over enable 1 changes nothing.
- R9: When several events arrive in the same cycle, they apply in this order: acknowledge, DONE-clear, control write, DONE-set, seek-complete. Each event sees the DONE and enable values left by the events before it.
- R10: Reset produces these values: queue 0, `irq_o` 0, `drive_id_o` 0, last drive 0, `vector_o` 0, DONE 1, enable 0.
- R11: Every output changes on the clock edge that samples the strobe. `irq_o` is never high while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_i | input | 1 | Bus interrupt acknowledge strobe |
| done_set_i | input | 1 | DONE becomes 1 |
| done_clr_i | input | 1 | DONE becomes 0 |
| seek_done_i | input | 1 | A drive finished its seek |
| seek_drv_i | input | 3 | Drive that finished the seek |
| csr_wr_i | input | 1 | Control register write strobe |
| csr_ie_i | input | 1 | Interrupt-enable value carried by the write |
| cmd_load_i | input | 1 | A non-reset command started |
| cmd_drv_i | input | 3 | Drive addressed by that command |
| irq_o | output | 1 | Interrupt request line |
| intq_o | output | 9 | Pending queue |
| drive_id_o | output | 3 | Drive-identity status field |
| vector_o | output | 8 | Vector returned by the last acknowledge |

## Verification
Some properties are checked on every cycle: the request line is never up over an empty queue; a DONE-clear always leaves the line down; a disabling control write always empties the queue; an isolated acknowledge removes exactly one pending bit; and an enabled seek always lands in its drive's bit. Other behaviour can only be shown by the bench's scenarios. These are the value loaded into the drive-identity field, the fixed ordering of events that arrive in the same cycle, the rule that a seek waits without raising the line while DONE is low, and the fact that a repeated enable write has no effect. The bench covers them with directed sequences and a long seeded random run, compared against a cycle model.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
    parameter int unsigned DRIVES = 8;
    localparam int unsigned DRV_W = $clog2(DRIVES);
    localparam int unsigned Q_W   = DRIVES + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RAISED = 2'd2
    } irqq_state_e;
endpackage

// File: rtl/irqq_pick.sv
// Lowest-set-bit selector: one-hot grant plus its index.
module irqq_pick #(
    parameter int unsigned Q_W   = 9,
    parameter int unsigned IDX_W = $clog2(Q_W)
) (
    input  logic [Q_W-1:0]   req,
    output logic             any,
    output logic [Q_W-1:0]   grant,
    output logic [IDX_W-1:0] idx
);
    logic [Q_W:0] below;

    assign below[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < Q_W; g++) begin : g_chain
            assign below[g+1] = below[g] | req[g];
            assign grant[g]   = req[g] & ~below[g];
        end
    endgenerate

    assign any = below[Q_W];

    always_comb begin
        idx = '0;
        for (int i = 0; i < Q_W; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqq_next.sv
// Applies one cycle's events to the queue state in fixed order.
module irqq_next #(
    parameter int unsigned Q_W   = 9,
    parameter int unsigned DRV_W = 3,
    parameter int unsigned IDX_W = $clog2(Q_W),
    parameter int unsigned VEC_W = 8,
    parameter logic [VEC_W-1:0] VECTOR = 8'h90
) (
    input  logic [Q_W-1:0]   q_cur,
    input  logic             req_cur,
    input  logic             done_cur,
    input  logic             ie_cur,
    input  logic [DRV_W-1:0] last_drv,
    input  logic [DRV_W-1:0] did_cur,
    input  logic [VEC_W-1:0] vec_cur,
    input  logic             pick_any,
    input  logic [Q_W-1:0]   pick_grant,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             ack,
    input  logic             done_clr,
    input  logic             csr_wr,
    input  logic             csr_ie,
    input  logic             done_set,
    input  logic             seek_done,
    input  logic [DRV_W-1:0] seek_drv,
    output logic [Q_W-1:0]   q_nxt,
    output logic             req_nxt,
    output logic             done_nxt,
    output logic             ie_nxt,
    output logic [DRV_W-1:0] did_nxt,
    output logic [VEC_W-1:0] vec_nxt
);
    logic [IDX_W-1:0] seek_bit;
    assign seek_bit = IDX_W'(seek_drv) + IDX_W'(1);

    always_comb begin
        q_nxt    = q_cur;
        req_nxt  = req_cur;
        done_nxt = done_cur;
        ie_nxt   = ie_cur;
        did_nxt  = did_cur;
        vec_nxt  = vec_cur;

        // acknowledge
        if (ack) begin
            if (pick_any) begin
                q_nxt   = q_nxt & ~pick_grant;
                vec_nxt = VECTOR;
                did_nxt = (pick_idx == '0) ? last_drv : DRV_W'(pick_idx - IDX_W'(1));
                req_nxt = |(q_nxt);
            end else begin
                q_nxt   = '0;
                vec_nxt = '0;
                req_nxt = 1'b0;
            end
        end

        // DONE cleared
        if (done_clr) begin
            done_nxt = 1'b0;
            q_nxt[0] = 1'b0;
            req_nxt  = 1'b0;
        end

        // control register write
        if (csr_wr) begin
            if (!csr_ie) begin
                q_nxt   = '0;
                req_nxt = 1'b0;
            end else if (done_nxt && !ie_nxt) begin
                q_nxt[0] = 1'b1;
                req_nxt  = 1'b1;
            end
            ie_nxt = csr_ie;
        end

        // DONE set
        if (done_set) begin
            done_nxt = 1'b1;
            if (ie_nxt) begin
                q_nxt[0] = 1'b1;
                req_nxt  = 1'b1;
            end else begin
                q_nxt   = '0;
                req_nxt = 1'b0;
            end
        end

        // seek complete
        if (seek_done) begin
            if (ie_nxt) begin
                q_nxt[seek_bit] = 1'b1;
                if (done_nxt) req_nxt = 1'b1;
            end else begin
                q_nxt   = '0;
                req_nxt = 1'b0;
            end
        end
    end
endmodule

// File: rtl/irqq_top.sv
module irqq_top
    import irqq_pkg::*;
#(
    parameter int unsigned N_DRV  = irqq_pkg::DRIVES,
    parameter int unsigned VEC_W  = 8,
    parameter logic [VEC_W-1:0] VECTOR = 8'h90,
    localparam int unsigned DW    = $clog2(N_DRV),
    localparam int unsigned QW    = N_DRV + 1,
    localparam int unsigned IW    = $clog2(QW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_i,
    input  logic          done_set_i,
    input  logic          done_clr_i,
    input  logic          seek_done_i,
    input  logic [DW-1:0] seek_drv_i,
    input  logic          csr_wr_i,
    input  logic          csr_ie_i,
    input  logic          cmd_load_i,
    input  logic [DW-1:0] cmd_drv_i,
    output logic          irq_o,
    output logic [QW-1:0] intq_o,
    output logic [DW-1:0] drive_id_o,
    output logic [VEC_W-1:0] vector_o
);
    irqq_state_e state_q, state_d;

    logic [QW-1:0]    q_q, q_d;
    logic             done_q, done_d;
    logic             ie_q, ie_d;
    logic [DW-1:0]    last_q;
    logic [DW-1:0]    did_q, did_d;
    logic [VEC_W-1:0] vec_q, vec_d;
    logic             req_cur, req_d;
    logic             p_any;
    logic [QW-1:0]    p_grant;
    logic [IW-1:0]    p_idx;

    irqq_pick #(.Q_W(QW), .IDX_W(IW)) u_pick (
        .req   (q_q),
        .any   (p_any),
        .grant (p_grant),
        .idx   (p_idx)
    );

    irqq_next #(
        .Q_W(QW), .DRV_W(DW), .IDX_W(IW), .VEC_W(VEC_W), .VECTOR(VECTOR)
    ) u_next (
        .q_cur      (q_q),
        .req_cur    (req_cur),
        .done_cur   (done_q),
        .ie_cur     (ie_q),
        .last_drv   (last_q),
        .did_cur    (did_q),
        .vec_cur    (vec_q),
        .pick_any   (p_any),
        .pick_grant (p_grant),
        .pick_idx   (p_idx),
        .ack        (ack_i),
        .done_clr   (done_clr_i),
        .csr_wr     (csr_wr_i),
        .csr_ie     (csr_ie_i),
        .done_set   (done_set_i),
        .seek_done  (seek_done_i),
        .seek_drv   (seek_drv_i),
        .q_nxt      (q_d),
        .req_nxt    (req_d),
        .done_nxt   (done_d),
        .ie_nxt     (ie_d),
        .did_nxt    (did_d),
        .vec_nxt    (vec_d)
    );

    // Transitions: raise, park, drain.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HOLD, ST_RAISED: begin
                if (q_d == '0)  state_d = ST_IDLE;
                else if (req_d) state_d = ST_RAISED;
                else            state_d = ST_HOLD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            q_q     <= '0;
            done_q  <= 1'b1;
            ie_q    <= 1'b0;
            last_q  <= '0;
            did_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            q_q     <= q_d;
            done_q  <= done_d;
            ie_q    <= ie_d;
            did_q   <= did_d;
            vec_q   <= vec_d;
            if (cmd_load_i) last_q <= cmd_drv_i;
        end
    end

    // Outputs from state.
    always_comb begin
        req_cur = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_cur = 1'b0;
            ST_HOLD:   req_cur = 1'b0;
            ST_RAISED: req_cur = 1'b1;
            default:   req_cur = 1'b0;
        endcase
    end

    assign irq_o      = req_cur;
    assign intq_o     = q_q;
    assign drive_id_o = did_q;
    assign vector_o   = vec_q;
endmodule

// File: rtl/irqq_chk.sv
module irqq_chk #(
    parameter int unsigned QW = 9,
    parameter int unsigned DW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_i,
    input logic          done_set_i,
    input logic          done_clr_i,
    input logic          seek_done_i,
    input logic [DW-1:0] seek_drv_i,
    input logic          csr_wr_i,
    input logic          csr_ie_i,
    input logic          ie_q,
    input logic          irq_o,
    input logic [QW-1:0] intq_o,
    input logic [7:0]    vector_o
);
    logic       quiet;
    logic       ie_eff;
    logic [3:0] sbit;
    assign quiet  = !done_clr_i && !csr_wr_i && !done_set_i && !seek_done_i;
    assign ie_eff = csr_wr_i ? csr_ie_i : ie_q;
    assign sbit   = 4'(seek_drv_i) + 4'd1;

    assert_irq_needs_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (intq_o != '0));

    assert_done_clr_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr_i && !csr_wr_i && !done_set_i && !seek_done_i) |=> !irq_o);

    assert_disable_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_i && !csr_ie_i) |=> (intq_o == '0 && !irq_o));

    assert_ack_removes_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && quiet && intq_o != '0) |=>
        ($countones(intq_o) + 1 == $countones($past(intq_o))));

    assert_empty_ack_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && quiet && intq_o == '0) |=> (vector_o == 8'h00 && intq_o == '0));

    assert_seek_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_done_i && ie_eff) |=> intq_o[$past(sbit)]);
endmodule

bind irqq_top irqq_chk #(.QW(QW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .done_set_i  (done_set_i),
    .done_clr_i  (done_clr_i),
    .seek_done_i (seek_done_i),
    .seek_drv_i  (seek_drv_i),
    .csr_wr_i    (csr_wr_i),
    .csr_ie_i    (csr_ie_i),
    .ie_q        (ie_q),
    .irq_o       (irq_o),
    .intq_o      (intq_o),
    .vector_o    (vector_o)
);

// File: tb/irqq_top_tb.sv
module irqq_top_tb;
    localparam logic [7:0] VEC = 8'h90;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_i = 0, done_set_i = 0, done_clr_i = 0, seek_done_i = 0;
    logic [2:0] seek_drv_i = '0, cmd_drv_i = '0;
    logic       csr_wr_i = 0, csr_ie_i = 0, cmd_load_i = 0;
    logic       irq_o;
    logic [8:0] intq_o;
    logic [2:0] drive_id_o;
    logic [7:0] vector_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    irqq_top u_dut (
        .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .done_set_i(done_set_i),
        .done_clr_i(done_clr_i), .seek_done_i(seek_done_i), .seek_drv_i(seek_drv_i),
        .csr_wr_i(csr_wr_i), .csr_ie_i(csr_ie_i), .cmd_load_i(cmd_load_i),
        .cmd_drv_i(cmd_drv_i), .irq_o(irq_o), .intq_o(intq_o),
        .drive_id_o(drive_id_o), .vector_o(vector_o)
    );

    // Reference model state
    logic [8:0] m_q;
    logic       m_req, m_done, m_ie;
    logic [2:0] m_ld, m_did;
    logic [7:0] m_vec;

    task automatic m_reset();
        m_q = '0; m_req = 0; m_done = 1; m_ie = 0; m_ld = '0; m_did = '0; m_vec = '0;
    endtask

    function automatic int lowest(input logic [8:0] q);
        for (int i = 8; i >= 0; i--) if (q[i]) lowest = i;
        if (q == '0) lowest = -1;
    endfunction

    task automatic m_step();
        int k;
        if (ack_i) begin
            k = lowest(m_q);
            if (k >= 0) begin
                m_q[k] = 1'b0; m_vec = VEC;
                m_did = (k == 0) ? m_ld : 3'(k - 1);
                m_req = (m_q != '0);
            end else begin
                m_q = '0; m_vec = '0; m_req = 0;
            end
        end
        if (done_clr_i) begin m_done = 0; m_q[0] = 0; m_req = 0; end
        if (csr_wr_i) begin
            if (!csr_ie_i) begin m_q = '0; m_req = 0; end
            else if (m_done && !m_ie) begin m_q[0] = 1; m_req = 1; end
            m_ie = csr_ie_i;
        end
        if (done_set_i) begin
            m_done = 1;
            if (m_ie) begin m_q[0] = 1; m_req = 1; end
            else begin m_q = '0; m_req = 0; end
        end
        if (seek_done_i) begin
            if (m_ie) begin m_q[seek_drv_i + 4'd1] = 1; if (m_done) m_req = 1; end
            else begin m_q = '0; m_req = 0; end
        end
        if (cmd_load_i) m_ld = cmd_drv_i;
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " irq"},   int'(irq_o),      int'(m_req));
        chk({tag, " intq"},  int'(intq_o),     int'(m_q));
        chk({tag, " id"},    int'(drive_id_o), int'(m_did));
        chk({tag, " vec"},   int'(vector_o),   int'(m_vec));
    endtask

    task automatic idle_in();
        ack_i = 0; done_set_i = 0; done_clr_i = 0; seek_done_i = 0;
        csr_wr_i = 0; csr_ie_i = 0; cmd_load_i = 0;
    endtask

    // Called at a negedge with inputs driven; returns at the next negedge.
    task automatic tick(input string tag);
        m_step();
        @(posedge clk);
        @(negedge clk);
        chk_all(tag);
        idle_in();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_all("R10 reset");

        // R3 setup: load last drive 5
        cmd_load_i = 1; cmd_drv_i = 3'd5; tick("R3 load");
        // R8 enable with DONE=1 from reset
        csr_wr_i = 1; csr_ie_i = 1; tick("R8 enable");
        chk("R8 literal", int'({irq_o, intq_o}), 10'h201);
        ack_i = 1; tick("R3 ack ctrl");
        chk("R3 literal id", int'(drive_id_o), 5);
        chk("R4 literal vec", int'(vector_o), int'(VEC));
        ack_i = 1; tick("R4 empty ack");
        chk("R4 literal zero", int'(vector_o), 0);
        done_clr_i = 1; tick("R6 clr");
        seek_done_i = 1; seek_drv_i = 3'd2; tick("R7 seek DONE low");
        chk("R7 literal held", int'({irq_o, intq_o}), 10'h008);
        seek_done_i = 1; seek_drv_i = 3'd7; tick("R1 seek drive 7");
        done_set_i = 1; tick("R5 set");
        chk("R1 literal", int'(intq_o), 9'h109);
        ack_i = 1; tick("R2 ack keeps irq");
        chk("R2 literal", int'(irq_o), 1);
        ack_i = 1; tick("R3 ack drive 2");
        chk("R3 literal drive", int'(drive_id_o), 2);
        done_clr_i = 1; tick("R6 keep drive bits");
        chk("R6 literal", int'({irq_o, intq_o}), 10'h100);
        csr_wr_i = 1; csr_ie_i = 1; tick("R8 repeat enable");
        csr_wr_i = 1; csr_ie_i = 0; tick("R8 disable");
        done_set_i = 1; tick("R5 set disabled");
        done_clr_i = 1; done_set_i = 1; tick("R9 clr then set");
        csr_wr_i = 1; csr_ie_i = 1; tick("R8 re-enable");
        ack_i = 1; seek_done_i = 1; seek_drv_i = 3'd0; tick("R9 ack plus seek");
        chk("R9 literal", int'({irq_o, intq_o}), 10'h202);
        seek_done_i = 1; seek_drv_i = 3'd4; csr_wr_i = 1; csr_ie_i = 0;
        tick("R9 disable before seek");

        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 4000; n++) begin
            ack_i       = ($urandom % 4) == 0;
            done_set_i  = ($urandom % 6) == 0;
            done_clr_i  = ($urandom % 7) == 0;
            seek_done_i = ($urandom % 3) == 0;
            seek_drv_i  = 3'($urandom);
            csr_wr_i    = ($urandom % 10) == 0;
            csr_ie_i    = ($urandom % 4) != 0;
            cmd_load_i  = ($urandom % 5) == 0;
            cmd_drv_i   = 3'($urandom);
            tick("R11 random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule